// File: doc/BRIEF.md
# Link Training Watchdog Sequencer

This block brings a serial link up from a cold start and watches it until it is established. On a start pulse it pins the controller's target speed to first generation, then enables the link training state machine and checks the link status at a fixed microsecond interval. A check succeeds when the controller reports the link up and no longer training. Each unsuccessful check reads a receiver status register in the PHY through a request/acknowledge port to a PHY register access engine.

While the speed change is in progress, the training state machine can end up in receiver-lock recovery with the receiver reporting no valid data. When a check sees that combination, the sequencer applies a timed cure. It reads the receiver override register, sets the data-enable and PLL-enable override bits, and holds them for a fixed recovery time. It then reads the register again and writes it back with both bits cleared. Polling then resumes, and the poll count is not reset. When the count of unsuccessful checks reaches a limit, the sequencer stops and reports failure. Both the done and the fail indication hold until the next start pulse.

Top module: `link_train_seq`

## Requirements
- R1: After reset, done_o, fail_o, ltssm_en_o and phy_req_o are 0 and speed_o equals SPEED_RST.
- R2: A start pulse accepted while idle, done or failed drives speed_o to 1 (first generation) at least one clock before ltssm_en_o rises. ltssm_en_o then stays high until the next accepted start.
- R3: The link counts as established only when a check samples link_up_i=1 and in_training_i=0. The sequencer then sets done_o, which holds until the next start, and issues no further PHY access.
- R4: Each unsuccessful check issues one PHY read (phy_we_o=0) of address 0x100D. Bit 0 of the returned data is the receiver-valid flag.
- R5: A stall is flagged only when that read returns bit 0 = 0 and ltssm_state_i equals 6'h0D in the acknowledge cycle. Every other combination causes no PHY write.
- R6: Recovery is a read of address 0x1005 followed by a write of the value read OR 16'h0028 (bit 5 and bit 3 set), then a hold, then a second read of 0x1005 and a write of the value read AND NOT 16'h0028. All other bits are preserved.
- R7: The hold between the acknowledge of the setting write and the next request lasts at least RECOV_US*CLK_HZ/1e6 clocks and no more than 3 clocks longer.
- R8: Consecutive receiver-status reads with no recovery between them are spaced by POLL_US*CLK_HZ/1e6 clocks, plus no more than 4 clocks.
- R9: After MAX_POLLS unsuccessful checks, fail_o is set. Checks that led to a recovery count toward this limit, because recovery does not reset the count.
- R10: fail_o holds until a start pulse is accepted. The accepting clock edge clears both done_o and fail_o.
- R11: A start pulse while a sequence is running has no effect.
- R12: phy_req_o, once raised, is held with stable phy_addr_o, phy_we_o and phy_wdata_o until phy_ack_i is sampled high. It drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| link_up_i | input | 1 | Controller reports link up |
| in_training_i | input | 1 | Controller reports link training in progress |
| ltssm_state_i | input | LTSSM_W | Training state machine state code |
| speed_o | output | SPEED_W | Target link speed field to the controller |
| ltssm_en_o | output | 1 | Training state machine enable |
| phy_req_o | output | 1 | PHY register access request |
| phy_we_o | output | 1 | 1 = write, 0 = read |
| phy_addr_o | output | PHY_AW | PHY register address |
| phy_wdata_o | output | PHY_DW | PHY write data |
| phy_ack_i | input | 1 | Access complete, one clock |
| phy_rdata_i | input | PHY_DW | Read data, valid with phy_ack_i |
| done_o | output | 1 | Link established (sticky) |
| fail_o | output | 1 | Poll limit reached (sticky) |

## Verification
The bench builds the block with CLK_HZ=2_000_000, POLL_US=10, RECOV_US=25 and MAX_POLLS=6. These values give a 2-clock microsecond tick, a 20-clock poll spacing and a 50-clock recovery hold. With them, a complete failure run, including one that cures a stall on every poll, finishes in a few hundred clocks. The poll limit, the non-reset of the count across recoveries and the exact hold windows can therefore all be measured directly at the ports.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam logic [15:0] RX_STAT_ADDR    = 16'h100D;
  localparam logic [15:0] RX_OVRD_ADDR    = 16'h1005;
  // bit 5: rx data enable override, bit 3: rx PLL enable override
  localparam logic [15:0] RX_OVRD_MASK    = 16'h0028;
  localparam logic [5:0]  LTSSM_RCVR_LOCK = 6'h0D;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FORCE,
    S_ENABLE,
    S_CHECK,
    S_RXRD,
    S_SET_RD,
    S_SET_WR,
    S_HOLD,
    S_CLR_RD,
    S_CLR_WR,
    S_WAIT,
    S_DONE,
    S_FAIL
  } seq_state_e;
endpackage

// File: rtl/lts_us_timer.sv
module lts_us_timer #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned CNT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] us_i,
  output logic             done_o
);
  localparam int unsigned DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;

  logic             active_q;
  logic [CNT_W-1:0] us_q;
  logic             tick;

  generate
    if (DIV == 1) begin : g_nopre
      assign tick = active_q;
    end else begin : g_pre
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              pre_q <= '0;
        else if (load_i)          pre_q <= PW'(DIV - 1);
        else if (active_q) begin
          if (pre_q == '0)        pre_q <= PW'(DIV - 1);
          else                    pre_q <= pre_q - 1'b1;
        end
      end
      assign tick = active_q && (pre_q == '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      us_q     <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      us_q     <= us_i;
    end else if (tick) begin
      if (us_q <= CNT_W'(1)) active_q <= 1'b0;
      else                   us_q     <= us_q - 1'b1;
    end
  end

  assign done_o = tick && (us_q <= CNT_W'(1)) && !load_i;
endmodule

// File: rtl/lts_poll_ctr.sv
module lts_poll_ctr #(
  parameter int unsigned MAX_POLLS = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = $clog2(MAX_POLLS + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q >= W'(MAX_POLLS - 1));
endmodule

// File: rtl/lts_phy_master.sv
module lts_phy_master #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          phy_req_o,
  output logic          phy_we_o,
  output logic [AW-1:0] phy_addr_o,
  output logic [DW-1:0] phy_wdata_o,
  input  logic          phy_ack_i,
  input  logic [DW-1:0] phy_rdata_i
);
  logic          busy_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q  <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end else if (phy_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign done_o      = busy_q && phy_ack_i;
  assign rdata_o     = phy_rdata_i;
  assign phy_req_o   = busy_q;
  assign phy_we_o    = we_q;
  assign phy_addr_o  = addr_q;
  assign phy_wdata_o = wdata_q;
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lts_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned POLL_US   = 10,
  parameter int unsigned RECOV_US  = 3000,
  parameter int unsigned MAX_POLLS = 4000,
  parameter int unsigned SPEED_W   = 4,
  parameter int unsigned SPEED_RST = 2,
  parameter int unsigned LTSSM_W   = 6,
  parameter int unsigned PHY_AW    = 16,
  parameter int unsigned PHY_DW    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               link_up_i,
  input  logic               in_training_i,
  input  logic [LTSSM_W-1:0] ltssm_state_i,
  output logic [SPEED_W-1:0] speed_o,
  output logic               ltssm_en_o,
  output logic               phy_req_o,
  output logic               phy_we_o,
  output logic [PHY_AW-1:0]  phy_addr_o,
  output logic [PHY_DW-1:0]  phy_wdata_o,
  input  logic               phy_ack_i,
  input  logic [PHY_DW-1:0]  phy_rdata_i,
  output logic               done_o,
  output logic               fail_o
);
  localparam int unsigned MAX_US = (POLL_US > RECOV_US) ? POLL_US : RECOV_US;
  localparam int unsigned TW     = $clog2(MAX_US + 1);
  localparam logic [PHY_DW-1:0] OVRD_MASK = PHY_DW'(RX_OVRD_MASK);

  seq_state_e state_q, state_d;

  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_us;
  logic              pc_clr, pc_inc, pc_last;
  logic              acc_valid, acc_we, acc_done;
  logic [PHY_AW-1:0] acc_addr;
  logic [PHY_DW-1:0] acc_rdata;
  logic [PHY_DW-1:0] ovrd_q;
  logic              stalled;

  lts_us_timer #(.CLK_HZ(CLK_HZ), .CNT_W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .us_i   (tmr_us),
    .done_o (tmr_done)
  );

  lts_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pc_clr),
    .inc_i  (pc_inc),
    .last_o (pc_last)
  );

  lts_phy_master #(.AW(PHY_AW), .DW(PHY_DW)) u_phy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (acc_valid),
    .we_i        (acc_we),
    .addr_i      (acc_addr),
    .wdata_i     (ovrd_q),
    .done_o      (acc_done),
    .rdata_o     (acc_rdata),
    .phy_req_o   (phy_req_o),
    .phy_we_o    (phy_we_o),
    .phy_addr_o  (phy_addr_o),
    .phy_wdata_o (phy_wdata_o),
    .phy_ack_i   (phy_ack_i),
    .phy_rdata_i (phy_rdata_i)
  );

  assign stalled = !acc_rdata[0] && (ltssm_state_i == LTSSM_W'(LTSSM_RCVR_LOCK));

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_us    = TW'(POLL_US);
    pc_clr    = 1'b0;
    pc_inc    = 1'b0;
    acc_valid = 1'b0;
    acc_we    = 1'b0;
    acc_addr  = PHY_AW'(RX_OVRD_ADDR);
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: begin
        if (start_i) begin
          state_d = S_FORCE;
          pc_clr  = 1'b1;
        end
      end
      S_FORCE:  state_d = S_ENABLE;
      S_ENABLE: state_d = S_CHECK;
      S_CHECK: begin
        if (link_up_i && !in_training_i) state_d = S_DONE;
        else                             state_d = S_RXRD;
      end
      S_RXRD: begin
        acc_valid = 1'b1;
        acc_addr  = PHY_AW'(RX_STAT_ADDR);
        if (acc_done) begin
          if (stalled) begin
            state_d = S_SET_RD;
          end else begin
            tmr_load = 1'b1;
            state_d  = S_WAIT;
          end
        end
      end
      S_SET_RD: begin
        acc_valid = 1'b1;
        if (acc_done) state_d = S_SET_WR;
      end
      S_SET_WR: begin
        acc_valid = 1'b1;
        acc_we    = 1'b1;
        if (acc_done) begin
          tmr_load = 1'b1;
          tmr_us   = TW'(RECOV_US);
          state_d  = S_HOLD;
        end
      end
      S_HOLD: if (tmr_done) state_d = S_CLR_RD;
      S_CLR_RD: begin
        acc_valid = 1'b1;
        if (acc_done) state_d = S_CLR_WR;
      end
      S_CLR_WR: begin
        acc_valid = 1'b1;
        acc_we    = 1'b1;
        if (acc_done) begin
          tmr_load = 1'b1;
          state_d  = S_WAIT;
        end
      end
      S_WAIT: begin
        if (tmr_done) begin
          if (pc_last) begin
            state_d = S_FAIL;
          end else begin
            pc_inc  = 1'b1;
            state_d = S_CHECK;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      ovrd_q     <= '0;
      speed_o    <= SPEED_W'(SPEED_RST);
      ltssm_en_o <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_d == S_DONE);
      fail_o  <= (state_d == S_FAIL);
      if (state_d == S_FORCE)  ltssm_en_o <= 1'b0;
      if (state_q == S_FORCE)  speed_o    <= SPEED_W'(1);
      if (state_q == S_ENABLE) ltssm_en_o <= 1'b1;
      if (acc_done && state_q == S_SET_RD) ovrd_q <= acc_rdata | OVRD_MASK;
      if (acc_done && state_q == S_CLR_RD) ovrd_q <= acc_rdata & ~OVRD_MASK;
    end
  end
endmodule

// File: rtl/lts_chk.sv
module lts_chk #(
  parameter int unsigned SPEED_W = 4,
  parameter int unsigned PHY_AW  = 16,
  parameter int unsigned PHY_DW  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [SPEED_W-1:0] speed_o,
  input logic               ltssm_en_o,
  input logic               phy_req_o,
  input logic               phy_we_o,
  input logic [PHY_AW-1:0]  phy_addr_o,
  input logic [PHY_DW-1:0]  phy_wdata_o,
  input logic               phy_ack_i,
  input logic               done_o,
  input logic               fail_o
);
  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i |=> phy_req_o && $stable(phy_addr_o) && $stable(phy_we_o) && $stable(phy_wdata_o));
  // R12
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_ack_i |=> !phy_req_o);
  // R2
  speed_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ltssm_en_o) |-> (speed_o == SPEED_W'(1)) && ($past(speed_o) == SPEED_W'(1)));
  // R10
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);
  // R3
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  // R3
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !phy_req_o && !fail_o);
  // R6
  write_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_we_o |-> phy_addr_o == PHY_AW'(16'h1005) &&
      ((phy_wdata_o[5] && phy_wdata_o[3]) || (!phy_wdata_o[5] && !phy_wdata_o[3])));
  // R4
  access_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> ltssm_en_o);
endmodule

bind link_train_seq lts_chk #(.SPEED_W(SPEED_W), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .speed_o     (speed_o),
  .ltssm_en_o  (ltssm_en_o),
  .phy_req_o   (phy_req_o),
  .phy_we_o    (phy_we_o),
  .phy_addr_o  (phy_addr_o),
  .phy_wdata_o (phy_wdata_o),
  .phy_ack_i   (phy_ack_i),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/sim_link_train_seq.sv
module sim_link_train_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  P_CYC = 20;   // POLL_US * DIV
  localparam int  R_CYC = 50;   // RECOV_US * DIV
  localparam int  NPOLL = 6;
  localparam logic [15:0] OVRD_INIT = 16'h8109;

  logic        clk = 0, rst_n = 0, start = 0;
  logic        link_up = 0, in_training = 0;
  logic [5:0]  ltssm = 6'h11;
  logic [3:0]  speed;
  logic        en, req, we, ack = 0, done, fail;
  logic [15:0] addr, wdata, rdata = 0;

  int checks = 0, failures = 0, cycles = 0;

  // PHY model state and statistics
  logic [15:0] ovrd_reg = OVRD_INIT;
  logic        rx_bit = 1'b1;
  int rx_rd = 0, ov_rd = 0, ov_wr = 0, lat = 0, gap = 0, prev_kind = 0;
  int rx_gap_min = 9999, rx_gap_max = 0, rec_gap = -1, n_req = 0;
  logic [15:0] w_first = 0, w_second = 0;
  logic prev_en = 0; logic [3:0] prev_speed = 0; int bad_order = 0, en_fall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_train_seq #(.CLK_HZ(2_000_000), .POLL_US(10), .RECOV_US(25), .MAX_POLLS(NPOLL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .link_up_i(link_up),
    .in_training_i(in_training), .ltssm_state_i(ltssm), .speed_o(speed),
    .ltssm_en_o(en), .phy_req_o(req), .phy_we_o(we), .phy_addr_o(addr),
    .phy_wdata_o(wdata), .phy_ack_i(ack), .phy_rdata_i(rdata),
    .done_o(done), .fail_o(fail));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      summary();
    end
    if (en && !prev_en && prev_speed != 4'd1) bad_order++;
    if (!en && prev_en) en_fall++;
    prev_en = en; prev_speed = speed;
    if (ack) begin ack = 0; rdata = 0; end
    if (!req) begin
      gap++; lat = 0;
    end else begin
      if (lat == 0) begin
        n_req++;
        if (addr == 16'h100D && prev_kind == 1) begin
          if (gap < rx_gap_min) rx_gap_min = gap;
          if (gap > rx_gap_max) rx_gap_max = gap;
        end
        if (addr == 16'h1005 && !we && prev_kind == 2) rec_gap = gap;
        gap = 0;
      end
      lat++;
      if (lat == 2) begin
        ack = 1;
        if (we) begin
          ovrd_reg = wdata;
          if (ov_wr == 0) w_first = wdata;
          if (ov_wr == 1) w_second = wdata;
          ov_wr++;
          prev_kind = (wdata & 16'h0028) != 0 ? 2 : 3;
        end else if (addr == 16'h100D) begin
          rdata = {15'h0, rx_bit}; rx_rd++; prev_kind = 1;
        end else begin
          rdata = ovrd_reg; ov_rd++; prev_kind = 3;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_stats();
    rx_rd = 0; ov_rd = 0; ov_wr = 0; n_req = 0; prev_kind = 0;
    rx_gap_min = 9999; rx_gap_max = 0; rec_gap = -1;
    w_first = 0; w_second = 0; bad_order = 0; en_fall = 0;
    ovrd_reg = OVRD_INIT;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_flag(input bit want_done, input int max);
    for (int i = 0; i < max; i++) begin
      if (want_done ? done : fail) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!done && !fail && !en && !req, "R1 flags after reset", {done, fail, en, req}, 0);
    check(speed == 4'd2, "R1 speed reset value", speed, 2);
  endtask

  task automatic t_fast_link();
    link_up = 1; in_training = 0; ltssm = 6'h11;
    clr_stats();
    pulse_start();
    wait_flag(1, 40);
    check(done && !fail, "R3 done on established link", {done, fail}, 2'b10);
    check(bad_order == 0 && speed == 4'd1 && en, "R2 speed forced before enable", bad_order, 0);
    repeat (30) @(negedge clk);
    check(n_req == 0, "R3 no PHY access after success", n_req, 0);
    check(done, "R3 done sticky", done, 1);
  endtask

  task automatic t_training_gate();
    link_up = 1; in_training = 1; ltssm = 6'h11; rx_bit = 1;
    pulse_start();
    clr_stats();
    for (int i = 0; i < 500 && rx_rd < 3; i++) @(negedge clk);
    check(!done && rx_rd == 3, "R3 in_training blocks success", {done, rx_rd[3:0]}, 3);
    check(ov_wr == 0, "R4 status read only, no write", ov_wr, 0);
    in_training = 0;
    wait_flag(1, 200);
    check(done, "R3 done after training ends", done, 1);
  endtask

  task automatic t_stuck_recover();
    link_up = 0; in_training = 0; ltssm = 6'h0D; rx_bit = 0;
    pulse_start();
    clr_stats();
    for (int i = 0; i < 800 && ov_wr < 2; i++) @(negedge clk);
    link_up = 1;
    check(w_first == 16'h8129, "R6 set write value", w_first, 16'h8129);
    check(w_second == 16'h8101, "R6 clear write value", w_second, 16'h8101);
    check(ov_rd == 2 && rx_rd == 1, "R5 stall triggers recovery", ov_rd, 2);
    check(rec_gap >= R_CYC && rec_gap <= R_CYC + 3, "R7 recovery hold", rec_gap, R_CYC);
    wait_flag(1, 200);
    check(done && !fail, "R9 polling resumes after recovery", done, 1);
  endtask

  task automatic t_stuck_fail();
    link_up = 0; ltssm = 6'h0D; rx_bit = 0;
    pulse_start();
    clr_stats();
    wait_flag(0, 3000);
    check(fail && !done, "R9 fail with recovery every poll", fail, 1);
    check(rx_rd == NPOLL - 0 || rx_rd == NPOLL, "R9 poll count not reset", rx_rd, NPOLL);
    check(ov_wr == 2 * NPOLL, "R9 recovery per poll", ov_wr, 2 * NPOLL);
  endtask

  task automatic t_not_stuck();
    link_up = 0; ltssm = 6'h0D; rx_bit = 1;
    pulse_start();
    clr_stats();
    wait_flag(0, 2000);
    check(fail && rx_rd == NPOLL, "R9 fail after limit", rx_rd, NPOLL);
    check(ov_wr == 0, "R5 rx_valid set blocks recovery", ov_wr, 0);
    check(rx_gap_min >= P_CYC && rx_gap_max <= P_CYC + 4, "R8 poll spacing", rx_gap_min, P_CYC);
    ltssm = 6'h0C; rx_bit = 0;
    pulse_start();
    clr_stats();
    wait_flag(0, 2000);
    check(fail && ov_wr == 0, "R5 other state blocks recovery", ov_wr, 0);
  endtask

  task automatic t_sticky_fail();
    repeat (40) @(negedge clk);
    link_up = 1; in_training = 0;
    repeat (10) @(negedge clk);
    check(fail && !done, "R10 fail holds without start", {fail, done}, 2'b10);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(!fail && !done, "R10 start clears fail", fail, 0);
    wait_flag(1, 40);
    check(done, "R10 restart succeeds", done, 1);
  endtask

  task automatic t_busy_start();
    link_up = 0; ltssm = 6'h11; rx_bit = 1;
    pulse_start();
    for (int i = 0; i < 200 && !en; i++) @(negedge clk);
    clr_stats();
    for (int i = 0; i < 500 && rx_rd < 2; i++) @(negedge clk);
    pulse_start();
    wait_flag(0, 2000);
    check(en_fall == 0, "R11 start while busy keeps enable", en_fall, 0);
    check(fail && rx_rd <= NPOLL, "R11 start while busy no restart", rx_rd, NPOLL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fast_link();
    t_training_gate();
    t_stuck_recover();
    t_stuck_fail();
    t_not_stuck();
    t_sticky_fail();
    t_busy_start();
    summary();
  end
endmodule